// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the value of a free-running 64-bit time counter at the moment a timing-protocol event packet passes the port. There are two independent capture channels, one for the receive direction and one for the transmit direction. Packet parsing and rule matching happen upstream and reach this block as a single-cycle event strobe per direction. Each strobe carries a 16-bit sequence identifier.

Each channel holds exactly one timestamp. The first event seen while the channel is armed is latched together with its sequence identifier, and a valid flag is raised. The channel then ignores further events until software writes a one to the valid flag position of that channel's status register. That write clears the held value and rearms the channel. A 3-bit enable field per channel gates capture, and only the all-ones value arms it. Software reads the held time as two 32-bit words through a small register port. Writes take effect at the next clock edge, and reads are combinational from the registered state.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset, every register reads zero: both status words, all four timestamp words and both enable fields. Both channels are therefore unable to capture.
- R2: An event strobe sampled while the channel's enable field equals 7 and no timestamp is held latches the time input from that clock edge and the strobe's sequence identifier. From the next cycle, the status word reads with bit 16 set and the identifier in bits 15:0.
- R3: The word address selects the register. Addresses 0 to 3 are receive status, receive time low word (bits 31:0), receive time high word (bits 63:32) and receive enable (bits 2:0). Addresses 4 to 7 hold the same four registers for transmit.
- R4: While bit 16 of a channel's status is set, further event strobes on that channel do not change its status or time words.
- R5: A write to a status address with data bit 16 set clears that channel's valid flag, sequence identifier and time words to zero. A status write with bit 16 clear changes nothing.
- R6: An event strobe in the same cycle as a clearing status write on an armed channel is captured. After that edge the channel holds the new event.
- R7: Capture happens only when the enable field held before the edge equals 7. Any other value, including 5 and 0, makes strobes have no effect. A new enable value applies from the cycle after its write.
- R8: The receive and transmit channels are independent. Events, clears and enable writes on one channel leave the other channel's registers unchanged.
- R9: Writes to the time word addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current value of the time counter |
| rx_event | input | 1 | Receive event strobe, one cycle |
| rx_seq_id | input | 16 | Sequence identifier for the receive strobe |
| tx_event | input | 1 | Transmit event strobe, one cycle |
| tx_seq_id | input | 16 | Sequence identifier for the transmit strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |

## Verification
The hardest case to reach is a clearing write and a new event strobe landing in the same clock edge. A bench that clears the latch and then waits for traffic never exercises it. The directed task first fills the channel, then drives the status write with bit 16 set, the strobe and a fresh time value in the same cycle. It expects the fresh value, not zeros. A second race, an enable write together with a strobe, is forced the same way to show that the old enable value governs that edge.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
    localparam int TS_W      = 64;
    localparam int SEQ_W     = 16;
    localparam int EN_W      = 3;
    localparam int WORD_W    = 32;
    localparam int VALID_BIT = 16;
    localparam int N_CHAN    = 2;
    localparam int REGS_PER  = 4;
    localparam int ADDR_W    = $clog2(N_CHAN * REGS_PER);
    localparam logic [EN_W-1:0] EN_ARMED = '1;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_TS_LO  = 2'd1,
        REG_TS_HI  = 2'd2,
        REG_ENABLE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic [SEQ_W-1:0]  seq;
        logic [TS_W-1:0]   ts;
        logic [EN_W-1:0]   en;
    } chan_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] ts_lo;
        logic [WORD_W-1:0] ts_hi;
        logic [WORD_W-1:0] enable;
    } chan_view_t;
endpackage

// File: rtl/ts_latch_chan.sv
module ts_latch_chan
    import ts_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   time_now,
    input  logic              evt,
    input  logic [SEQ_W-1:0]  seq_in,
    input  logic              wr_status,
    input  logic              wr_enable,
    input  logic              clr_bit,
    input  logic [EN_W-1:0]   en_val,
    output chan_view_t        view
);
    chan_state_t st_d, st_q;
    logic armed, clr_req, take;

    always_comb begin
        st_d    = st_q;
        armed   = (st_q.en == EN_ARMED);
        clr_req = wr_status && clr_bit;
        take    = evt && armed && (!st_q.valid || clr_req);
        if (wr_enable) begin
            st_d.en = en_val;
        end
        if (clr_req) begin
            st_d.valid = 1'b0;
            st_d.seq   = '0;
            st_d.ts    = '0;
        end
        if (take) begin
            st_d.valid = 1'b1;
            st_d.seq   = seq_in;
            st_d.ts    = time_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        view        = '0;
        view.status[SEQ_W-1:0] = st_q.seq;
        view.status[VALID_BIT] = st_q.valid;
        view.ts_lo  = st_q.ts[WORD_W-1:0];
        view.ts_hi  = st_q.ts[TS_W-1:WORD_W];
        view.enable[EN_W-1:0] = st_q.en;
    end

    // R2: armed, empty channel latches time and identifier
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && st_q.en == EN_ARMED && !st_q.valid)
        |=> (st_q.valid && st_q.ts == $past(time_now) && st_q.seq == $past(seq_in)));

    // R4: held value is frozen until a clearing write
    assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !(wr_status && clr_bit))
        |=> (st_q.valid && $stable(st_q.ts) && $stable(st_q.seq)));

    // R5: a clear without a concurrent capture empties the channel
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && clr_bit && !(evt && st_q.en == EN_ARMED))
        |=> (!st_q.valid && st_q.ts == '0));

    // R6: clear and event in one cycle keeps the new event
    assert_race_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && clr_bit && evt && st_q.en == EN_ARMED)
        |=> (st_q.valid && st_q.ts == $past(time_now)));

    // R7: a disarmed, empty channel stays empty
    assert_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.valid && st_q.en != EN_ARMED) |=> !st_q.valid);
endmodule

// File: rtl/ts_read_mux.sv
module ts_read_mux
    import ts_cap_pkg::*;
(
    input  chan_view_t         views [N_CHAN],
    input  logic [ADDR_W-1:0]  addr,
    output logic [WORD_W-1:0]  rdata
);
    localparam int SEL_W = $clog2(REGS_PER);
    chan_view_t cur;
    reg_sel_e   sel;

    always_comb begin
        cur = views[addr[ADDR_W-1:SEL_W]];
        sel = reg_sel_e'(addr[SEL_W-1:0]);
        unique case (sel)
            REG_STATUS: rdata = cur.status;
            REG_TS_LO:  rdata = cur.ts_lo;
            REG_TS_HI:  rdata = cur.ts_hi;
            REG_ENABLE: rdata = cur.enable;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
    import ts_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TS_W-1:0]    time_now,
    input  logic               rx_event,
    input  logic [SEQ_W-1:0]   rx_seq_id,
    input  logic               tx_event,
    input  logic [SEQ_W-1:0]   tx_seq_id,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata
);
    localparam int SEL_W = $clog2(REGS_PER);

    logic              evt_vec [N_CHAN];
    logic [SEQ_W-1:0]  seq_vec [N_CHAN];
    chan_view_t        views   [N_CHAN];
    logic              unused_wdata;

    assign evt_vec[0] = rx_event;
    assign evt_vec[1] = tx_event;
    assign seq_vec[0] = rx_seq_id;
    assign seq_vec[1] = tx_seq_id;
    assign unused_wdata = ^{bus_wdata[WORD_W-1:VALID_BIT+1],
                            bus_wdata[VALID_BIT-1:EN_W]};

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        logic hit;
        assign hit = bus_wr && (bus_addr[ADDR_W-1:SEL_W] == c[ADDR_W-SEL_W-1:0]);

        ts_latch_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .time_now  (time_now),
            .evt       (evt_vec[c]),
            .seq_in    (seq_vec[c]),
            .wr_status (hit && bus_addr[SEL_W-1:0] == REG_STATUS),
            .wr_enable (hit && bus_addr[SEL_W-1:0] == REG_ENABLE),
            .clr_bit   (bus_wdata[VALID_BIT]),
            .en_val    (bus_wdata[EN_W-1:0]),
            .view      (views[c])
        );
    end

    ts_read_mux u_mux (
        .views (views),
        .addr  (bus_addr),
        .rdata (bus_rdata)
    );
endmodule

// File: tb/sim_ts_capture_unit.sv
module sim_ts_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        rx_event = 1'b0, tx_event = 1'b0;
    logic [15:0] rx_seq_id = '0, tx_seq_id = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    ts_capture_unit u0 (.*);

    task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d actual %h expected %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic evt(input bit tx, input logic [15:0] s, input logic [63:0] t);
        @(negedge clk);
        time_now = t;
        if (tx) begin tx_event = 1'b1; tx_seq_id = s; end
        else    begin rx_event = 1'b1; rx_seq_id = s; end
        @(negedge clk);
        rx_event = 1'b0; tx_event = 1'b0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) chk(3'(a), 32'h0, "R1");
    endtask

    task automatic t_disabled;
        evt(0, 16'h0011, 64'h1111_2222_3333_4444);
        chk(3'd0, 32'h0, "R7");
        wr(3'd3, 32'h5);
        chk(3'd3, 32'h5, "R3");
        evt(0, 16'h0012, 64'h5);
        chk(3'd0, 32'h0, "R7");
        // enable write and event in the same cycle: old enable governs
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h7;
        rx_event = 1'b1; rx_seq_id = 16'h0013; time_now = 64'h9;
        @(negedge clk);
        bus_wr = 1'b0; rx_event = 1'b0;
        chk(3'd0, 32'h0, "R7");
        chk(3'd3, 32'h7, "R3");
    endtask

    task automatic t_capture;
        evt(0, 16'h1234, 64'h89AB_CDEF_0123_4567);
        chk(3'd0, 32'h0001_1234, "R2");
        chk(3'd1, 32'h0123_4567, "R3");
        chk(3'd2, 32'h89AB_CDEF, "R3");
        chk(3'd4, 32'h0, "R8");
    endtask

    task automatic t_locked;
        evt(0, 16'h5555, 64'hFFFF_0000_FFFF_0000);
        chk(3'd0, 32'h0001_1234, "R4");
        chk(3'd1, 32'h0123_4567, "R4");
        wr(3'd0, 32'h0000_FFFF);
        chk(3'd0, 32'h0001_1234, "R5");
        wr(3'd1, 32'hDEAD_BEEF);
        wr(3'd2, 32'hDEAD_BEEF);
        chk(3'd1, 32'h0123_4567, "R9");
        chk(3'd2, 32'h89AB_CDEF, "R9");
    endtask

    task automatic t_clear;
        wr(3'd0, 32'h0001_0000);
        chk(3'd0, 32'h0, "R5");
        chk(3'd1, 32'h0, "R5");
        chk(3'd2, 32'h0, "R5");
        evt(0, 16'h0042, 64'h0000_0001_0000_0002);
        chk(3'd0, 32'h0001_0042, "R2");
    endtask

    task automatic t_race;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h0001_0000;
        rx_event = 1'b1; rx_seq_id = 16'hBEEF; time_now = 64'h7777_6666_5555_4444;
        @(negedge clk);
        bus_wr = 1'b0; rx_event = 1'b0;
        chk(3'd0, 32'h0001_BEEF, "R6");
        chk(3'd1, 32'h5555_4444, "R6");
        chk(3'd2, 32'h7777_6666, "R6");
    endtask

    task automatic t_tx;
        evt(1, 16'h0A0A, 64'h1);
        chk(3'd4, 32'h0, "R7");
        wr(3'd7, 32'h7);
        chk(3'd7, 32'h7, "R3");
        evt(1, 16'h0A0B, 64'h0000_00AA_0000_00BB);
        chk(3'd4, 32'h0001_0A0B, "R8");
        chk(3'd5, 32'h0000_00BB, "R8");
        chk(3'd6, 32'h0000_00AA, "R8");
        chk(3'd0, 32'h0001_BEEF, "R8");
        wr(3'd0, 32'h0001_0000);
        chk(3'd4, 32'h0001_0A0B, "R8");
        wr(3'd7, 32'h0);
        chk(3'd3, 32'h7, "R8");
        wr(3'd4, 32'h0001_0000);
        evt(1, 16'h0A0C, 64'h3);
        chk(3'd4, 32'h0, "R7");
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_capture();
        t_locked();
        t_clear();
        t_race();
        t_tx();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule